// File: doc/BRIEF.md
# Same-Source Request Ordering Tracker

This block sits beside the switch allocator of a mesh router and covers the output ports that carry the globally ordered request class. For each such port it keeps a small table with one entry per virtual channel of the downstream router. Each entry records the source ID of the request currently held in that channel. An entry is filled when the local allocator sends a request through the port and assigns it a downstream channel. It is emptied when that channel's credit comes back, which happens once the request has left the downstream router on every output it needed.

Requests are told apart by source ID only. A later request from a source must therefore not overtake an earlier one from the same source. The tracker answers one combinational query per cycle with a source ID and the set of output ports the request will fork to. It returns a block flag that the allocator uses to mask the request.

The same query also reports, per port, which downstream channels the request may take. One channel per port is reserved for deadlock avoidance. It is offered only to the request whose source ID equals the ID that the downstream node currently expects next in the global order.

Top module: `sid_order_tracker`

## Requirements
- R1: After reset every table is empty. The query never blocks, and every non-reserved channel of every port is reported usable for any source ID.
- R2: An allocation on port p with channel v and source ID s makes the entry valid from the next cycle. From then on, a query for s whose port mask includes p is blocked.
- R3: A credit return for channel v on port p empties that entry from the next cycle. Channel v becomes usable again, and queries for its former source ID are no longer blocked by port p.
- R4: For a multicast, the query is blocked when any port set in the port mask (bit p = port p) holds a valid entry with the queried source ID. Ports outside the mask never block.
- R5: A valid entry never blocks a query carrying a different source ID.
- R6: If a credit return and a new allocation target the same channel of a port in the same cycle, the clear is applied first. The entry ends up valid and holds the newly allocated source ID.
- R7: A channel whose entry is valid is not reported usable. Usability of port p channel v is bit p*NUM_VC+v of the usable vector.
- R8: The reserved channel (index RSV_VC, default 0) of port p is reported usable only when it is empty and the queried source ID equals that port's expected-source input.
- R9: A credit return for an empty channel changes no entry and no query result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | NUM_PORTS | Per port: a request was granted this port and a downstream channel |
| alloc_vc | input | NUM_PORTS*VCW | Per port: allocated channel index, field p at bits p*VCW |
| alloc_sid | input | NUM_PORTS*SID_W | Per port: source ID of the allocated request |
| cred_valid | input | NUM_PORTS | Per port: a channel credit returned |
| cred_vc | input | NUM_PORTS*VCW | Per port: channel whose credit returned |
| ds_esid | input | NUM_PORTS*SID_W | Per port: source ID the downstream node expects next |
| qry_sid | input | SID_W | Source ID of the request being checked |
| qry_ports | input | NUM_PORTS | Output ports the request will use |
| qry_block | output | 1 | Request must not raise a switch request this cycle |
| qry_vc_ok | output | NUM_PORTS*NUM_VC | Channels the request may be allocated, bit p*NUM_VC+v |

## Verification
Each channel of each port is filled in turn with every source ID. While it is full, every source ID is queried against every port mask. This separates a match on the queried port from a match on a port outside the mask, and a matching ID from a neighbouring one. Alternating the expected-source input between the allocated ID and a different one shows the reserved channel opening only for the expected ID. Directed sequences cover a same-cycle credit and allocation on one channel, and a credit for an empty channel.

// File: rtl/sid_trk_pkg.sv
package sid_trk_pkg;
   // index width for a count of items, never below one bit
   function automatic int idx_w(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/sid_trk_table.sv
module sid_trk_table
   import sid_trk_pkg::*;
#(
   parameter int NUM_VC = 4,
   parameter int SID_W  = 6,
   localparam int VCW   = idx_w(NUM_VC)
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              alloc_valid,
   input  logic [VCW-1:0]    alloc_vc,
   input  logic [SID_W-1:0]  alloc_sid,
   input  logic              cred_valid,
   input  logic [VCW-1:0]    cred_vc,
   input  logic [SID_W-1:0]  qry_sid,
   output logic              hit,
   output logic [NUM_VC-1:0] occ
);
   logic [NUM_VC-1:0]             vld;
   logic [NUM_VC-1:0][SID_W-1:0]  sid_q;
   logic [NUM_VC-1:0]             hit_vec;
   logic [NUM_VC-1:0]             dup_vec;

   for (genvar v = 0; v < NUM_VC; v++) begin : g_ent
      logic wr_en, clr_en;
      assign wr_en  = alloc_valid && (alloc_vc == VCW'(v));
      assign clr_en = cred_valid  && (cred_vc  == VCW'(v));

      // clear first, then write: a write in the same cycle wins (R6)
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            vld[v]   <= 1'b0;
            sid_q[v] <= '0;
         end else if (wr_en) begin
            vld[v]   <= 1'b1;
            sid_q[v] <= alloc_sid;
         end else if (clr_en) begin
            vld[v]   <= 1'b0;
         end
      end

      assign hit_vec[v] = vld[v] && (sid_q[v] == qry_sid);
      // entry still holding the incoming SID after this cycle's clear
      assign dup_vec[v] = vld[v] && !clr_en && (sid_q[v] == alloc_sid);
   end

   assign hit = |hit_vec;
   assign occ = vld;

   // R7
   alloc_free_vc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_valid |-> (!vld[alloc_vc] || (cred_valid && cred_vc == alloc_vc)));

   // R2
   alloc_unique_sid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_valid |-> (dup_vec == '0));

   // R3
   occ_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(vld) <= $countones($past(vld)) + 1);

   // R9
   idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!alloc_valid && (!cred_valid || !vld[cred_vc])) |=> $stable(vld));
endmodule

// File: rtl/sid_trk_vc_gate.sv
module sid_trk_vc_gate #(
   parameter int NUM_VC = 4,
   parameter int SID_W  = 6,
   parameter int RSV_VC = 0,
   parameter bit RSV_EN = 1'b1
)(
   input  logic [NUM_VC-1:0] occ,
   input  logic [SID_W-1:0]  qry_sid,
   input  logic [SID_W-1:0]  esid,
   output logic [NUM_VC-1:0] ok
);
   for (genvar v = 0; v < NUM_VC; v++) begin : g_vc
      if (RSV_EN && v == RSV_VC) begin : g_rsv
         assign ok[v] = !occ[v] && (qry_sid == esid);
      end else begin : g_std
         assign ok[v] = !occ[v];
      end
   end
endmodule

// File: rtl/sid_order_tracker.sv
module sid_order_tracker
   import sid_trk_pkg::*;
#(
   parameter int NUM_PORTS = 5,
   parameter int NUM_VC    = 4,
   parameter int SID_W     = 6,
   parameter int RSV_VC    = 0,
   parameter bit RSV_EN    = 1'b1,
   localparam int VCW      = idx_w(NUM_VC)
)(
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [NUM_PORTS-1:0]          alloc_valid,
   input  logic [NUM_PORTS*VCW-1:0]      alloc_vc,
   input  logic [NUM_PORTS*SID_W-1:0]    alloc_sid,
   input  logic [NUM_PORTS-1:0]          cred_valid,
   input  logic [NUM_PORTS*VCW-1:0]      cred_vc,
   input  logic [NUM_PORTS*SID_W-1:0]    ds_esid,
   input  logic [SID_W-1:0]              qry_sid,
   input  logic [NUM_PORTS-1:0]          qry_ports,
   output logic                          qry_block,
   output logic [NUM_PORTS*NUM_VC-1:0]   qry_vc_ok
);
   if (NUM_PORTS < 1) begin : g_bad_ports
      $error("NUM_PORTS must be at least 1");
   end
   if (NUM_VC < 2) begin : g_bad_vc
      $error("NUM_VC must be at least 2");
   end
   if (RSV_EN && (RSV_VC < 0 || RSV_VC >= NUM_VC)) begin : g_bad_rsv
      $error("RSV_VC out of range");
   end
   if (SID_W < 1) begin : g_bad_sid
      $error("SID_W must be at least 1");
   end

   logic [NUM_PORTS-1:0] port_hit;

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      logic [NUM_VC-1:0] occ;
      logic [SID_W-1:0]  esid_p;
      logic [VCW-1:0]    avc_p;
      logic [SID_W-1:0]  asid_p;

      assign esid_p = ds_esid[p*SID_W +: SID_W];
      assign avc_p  = alloc_vc[p*VCW +: VCW];
      assign asid_p = alloc_sid[p*SID_W +: SID_W];

      sid_trk_table #(.NUM_VC(NUM_VC), .SID_W(SID_W)) u_tab (
         .clk        (clk),
         .rst_n      (rst_n),
         .alloc_valid(alloc_valid[p]),
         .alloc_vc   (avc_p),
         .alloc_sid  (asid_p),
         .cred_valid (cred_valid[p]),
         .cred_vc    (cred_vc[p*VCW +: VCW]),
         .qry_sid    (qry_sid),
         .hit        (port_hit[p]),
         .occ        (occ)
      );

      sid_trk_vc_gate #(.NUM_VC(NUM_VC), .SID_W(SID_W),
                        .RSV_VC(RSV_VC), .RSV_EN(RSV_EN)) u_gate (
         .occ    (occ),
         .qry_sid(qry_sid),
         .esid   (esid_p),
         .ok     (qry_vc_ok[p*NUM_VC +: NUM_VC])
      );

      if (RSV_EN) begin : g_rsv_chk
         // R8
         rsv_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (alloc_valid[p] && avc_p == VCW'(RSV_VC)) |-> (asid_p == esid_p));
      end
   end

   assign qry_block = |(port_hit & qry_ports);

   // R4
   mask_scope_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (qry_ports == '0) |-> !qry_block);
endmodule

// File: tb/sid_order_tracker_tb.sv
module sid_order_tracker_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int NP  = 2;
   localparam int NV  = 4;
   localparam int SW  = 3;
   localparam int VW  = 2;
   localparam int NS  = 1 << SW;
   localparam int RSV = 0;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NP-1:0]    alloc_valid = '0;
   logic [NP*VW-1:0] alloc_vc = '0;
   logic [NP*SW-1:0] alloc_sid = '0;
   logic [NP-1:0]    cred_valid = '0;
   logic [NP*VW-1:0] cred_vc = '0;
   logic [NP*SW-1:0] ds_esid = '0;
   logic [SW-1:0]    qry_sid = '0;
   logic [NP-1:0]    qry_ports = '0;
   logic             qry_block;
   logic [NP*NV-1:0] qry_vc_ok;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   bit       mv [NP][NV];
   int       ms [NP][NV];

   always #(CLK_PERIOD/2) clk = ~clk;

   sid_order_tracker #(.NUM_PORTS(NP), .NUM_VC(NV), .SID_W(SW), .RSV_VC(RSV)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .alloc_valid(alloc_valid), .alloc_vc(alloc_vc), .alloc_sid(alloc_sid),
      .cred_valid(cred_valid), .cred_vc(cred_vc), .ds_esid(ds_esid),
      .qry_sid(qry_sid), .qry_ports(qry_ports),
      .qry_block(qry_block), .qry_vc_ok(qry_vc_ok));

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic set_esid(input int p, input int s);
      ds_esid[p*SW +: SW] = SW'(s);
   endtask

   // sweep every SID and every port mask against the bench model
   task automatic chk_all(input string tag);
      for (int s = 0; s < NS; s++) begin
         for (int m = 0; m < (1 << NP); m++) begin
            logic exp_blk;
            logic [NP*NV-1:0] exp_ok;
            qry_sid = SW'(s);
            qry_ports = NP'(m);
            #1;
            exp_blk = 1'b0;
            for (int p = 0; p < NP; p++) begin
               for (int v = 0; v < NV; v++) begin
                  if (((m >> p) & 1) == 1 && mv[p][v] && ms[p][v] == s) exp_blk = 1'b1;
                  exp_ok[p*NV+v] = !mv[p][v] &&
                     (v != RSV || int'(ds_esid[p*SW +: SW]) == s);
               end
            end
            n_chk++;
            if (qry_block !== exp_blk || qry_vc_ok !== exp_ok) begin
               n_fail++;
               $display("FAIL %s sid=%0d mask=%0d: block=%b ok=%b expected block=%b ok=%b",
                        tag, s, m, qry_block, qry_vc_ok, exp_blk, exp_ok);
            end
         end
      end
      qry_ports = '0;
   endtask

   task automatic do_alloc(input int p, input int v, input int s);
      alloc_valid[p] = 1'b1;
      alloc_vc[p*VW +: VW] = VW'(v);
      alloc_sid[p*SW +: SW] = SW'(s);
      tick();
      alloc_valid = '0;
      mv[p][v] = 1'b1;
      ms[p][v] = s;
   endtask

   task automatic do_cred(input int p, input int v);
      cred_valid[p] = 1'b1;
      cred_vc[p*VW +: VW] = VW'(v);
      tick();
      cred_valid = '0;
      mv[p][v] = 1'b0;
   endtask

   initial begin
      for (int p = 0; p < NP; p++)
         for (int v = 0; v < NV; v++) begin mv[p][v] = 1'b0; ms[p][v] = 0; end
      set_esid(0, 2);
      set_esid(1, 5);
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      chk_all("R1 reset");

      // fill each channel with each SID in turn (R2, R4, R5, R7, R8), then release (R3)
      for (int p = 0; p < NP; p++) begin
         for (int v = 0; v < NV; v++) begin
            for (int s = 0; s < NS; s++) begin
               set_esid(p, s);
               do_alloc(p, v, s);
               if ((s & 1) == 1) set_esid(p, (s + 3) % NS);
               chk_all("R2/R4/R5/R7/R8 held");
               do_cred(p, v);
               chk_all("R3 released");
            end
         end
      end

      // two ports busy at once with different SIDs: multicast masks (R4)
      set_esid(0, 6);
      do_alloc(0, 2, 6);
      do_alloc(1, 3, 1);
      chk_all("R4 multicast");

      // R6: credit and allocation on one channel in the same cycle
      do_alloc(0, 1, 4);
      cred_valid[0] = 1'b1;
      cred_vc[0*VW +: VW] = VW'(1);
      alloc_valid[0] = 1'b1;
      alloc_vc[0*VW +: VW] = VW'(1);
      alloc_sid[0*SW +: SW] = SW'(3);
      tick();
      cred_valid = '0;
      alloc_valid = '0;
      mv[0][1] = 1'b1;
      ms[0][1] = 3;
      chk_all("R6 same-cycle");

      // R9: credit for an empty channel
      cred_valid[1] = 1'b1;
      cred_vc[1*VW +: VW] = VW'(0);
      tick();
      cred_valid = '0;
      chk_all("R9 empty credit");

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end
endmodule